// File: doc/BRIEF.md
# Power Button Controller With Long-Hold Override

This block turns an active-low mechanical power button into soft power-state control for a system. The raw pin is brought into the clock domain by two flops and then filtered by a tick-driven debounce stage, so contact bounce cannot count as a press. A slow tick input, typically 1 ms, sets the time base for debouncing and for hold timing.

Every recognised press sets a sticky press status. An interrupt request to software (SCI) is raised whenever a status bit and its enable are both set. When the system is off, a press turns it on. When the system is working, a short press only notifies software, which then shuts the system down in an orderly way by writing a soft-off command.

If a press that began in the working state is held for the long-hold threshold and the override is enabled, the block forces the system off in hardware and sets a separate override status. A small register port with two addresses gives access to the status and enable bits. It has no handshake: a write takes effect on the clock edge where the write strobe is high, and read data follows the address combinationally.

Top module: `pwrbtn_ctrl`

## Requirements
- R1: After reset, `sys_on` is 0, both status bits and both enable bits read 0, and `sci` is 0.
- R2: A press is recognised only after the synchronised pin has stayed low for DEB_TICKS consecutive ticks. A shorter low pulse sets no status and does not change `sys_on`.
- R3: A recognised press sets the press status, which is bit 0 at address 0, whatever the power state.
- R4: A recognised press while `sys_on` is 0 sets `sys_on` to 1.
- R5: A press while working leaves `sys_on` at 1. Writing 1 to bit 7 at address 1 (soft-off command) clears `sys_on`. Bit 7 always reads back as 0.
- R6: A press begun while working, with the override enabled (bit 1 at address 1), forces `sys_on` to 0 once it has been counted as pressed for HOLD_TICKS ticks. It also sets the override status, which is bit 1 at address 0.
- R7: With the override disabled, a long hold has the same effect as a short press. It does not force the system off and does not set the override status.
- R8: A press that began while off never triggers the override. The override fires at most once per press, and the hold count restarts with each new press.
- R9: Status bits are cleared by writing 1 to them at address 0. Writing 0 to a status bit leaves it unchanged.
- R10: `sci` equals (press status AND press enable) OR (override status AND override enable). The press enable is bit 0 at address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle time-base pulse |
| btn_n | input | 1 | Raw active-low power button |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address: 0 selects status, 1 selects enable/command |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| sys_on | output | 1 | Soft power state, 1 for working |
| sci | output | 1 | Interrupt request to software |

## Verification
The bench sweeps the length of the press from zero ticks to beyond the hold threshold. It repeats the sweep for every combination of starting power state, override enable and press enable. Press lengths below the debounce length separate glitch rejection from recognition. Lengths just below and at the hold threshold locate the exact tick on which the override fires. Starting from the off state shows that a long hold after power-on cannot immediately force the system off again. Separate sequences cover write-one-to-clear on single bits, the soft-off command, and two long presses in a row, which together show that the override happens once per press and re-arms on the next press.

// File: rtl/pwrbtn_pkg.sv
package pwrbtn_pkg;
  localparam int DW = 8;
  localparam logic ADDR_STS = 1'b0;
  localparam logic ADDR_EN  = 1'b1;
  localparam int BIT_PRESS = 0;
  localparam int BIT_OVR   = 1;
  localparam int BIT_OFF   = 7;

  typedef struct packed {
    logic ovr;
    logic press;
  } evt_bits_t;
endpackage

// File: rtl/pb_debounce.sv
module pb_debounce #(
  parameter int DEB_TICKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic btn_n,
  output logic pressed,
  output logic press_pulse
);
  localparam int CW = $clog2(DEB_TICKS + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          raw_pressed, mismatch, flip;

  assign raw_pressed = ~sync_q[1];
  assign mismatch    = raw_pressed != pressed;
  assign flip        = tick && mismatch && (cnt_q == CW'(DEB_TICKS - 1));
  assign press_pulse = flip && !pressed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      cnt_q   <= '0;
      pressed <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], btn_n};
      if (!mismatch) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (flip) begin
          cnt_q   <= '0;
          pressed <= ~pressed;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pb_hold_timer.sv
module pb_hold_timer #(
  parameter int HOLD_TICKS = 4001
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pressed,
  input  logic press_pulse,
  input  logic sys_on,
  output logic hold_done
);
  localparam int HW = $clog2(HOLD_TICKS + 1);

  logic [HW-1:0] cnt_q;
  logic          armed_q, fired_q, counting;

  assign counting  = tick && pressed && armed_q && !fired_q;
  assign hold_done = counting && (cnt_q == HW'(HOLD_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      fired_q <= 1'b0;
    end else if (press_pulse) begin
      cnt_q   <= '0;
      armed_q <= sys_on;
      fired_q <= 1'b0;
    end else if (!pressed) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      fired_q <= 1'b0;
    end else if (counting) begin
      if (hold_done) fired_q <= 1'b1;
      else           cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pb_regs.sv
module pb_regs
  import pwrbtn_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          press_pulse,
  input  logic          hold_done,
  output logic          sys_on,
  output logic          sci,
  output logic          ovr_en,
  output logic          soft_off_cmd,
  output evt_bits_t     sts
);
  evt_bits_t en_q;
  logic      wr_sts, wr_en, force_off;
  logic      unused_wdata;

  assign wr_sts       = reg_wr && (reg_addr == ADDR_STS);
  assign wr_en        = reg_wr && (reg_addr == ADDR_EN);
  assign soft_off_cmd = wr_en && reg_wdata[BIT_OFF];
  assign force_off    = hold_done && en_q.ovr;
  assign ovr_en       = en_q.ovr;
  assign unused_wdata = ^reg_wdata[BIT_OFF-1:BIT_OVR+1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sys_on <= 1'b0;
      sts    <= '0;
      en_q   <= '0;
    end else begin
      if (press_pulse && !sys_on)        sys_on <= 1'b1;
      else if (force_off || soft_off_cmd) sys_on <= 1'b0;
      sts.press <= (sts.press & ~(wr_sts & reg_wdata[BIT_PRESS])) | press_pulse;
      sts.ovr   <= (sts.ovr & ~(wr_sts & reg_wdata[BIT_OVR])) | force_off;
      if (wr_en) begin
        en_q.press <= reg_wdata[BIT_PRESS];
        en_q.ovr   <= reg_wdata[BIT_OVR];
      end
    end
  end

  assign sci = (sts.press & en_q.press) | (sts.ovr & en_q.ovr);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_STS) begin
      reg_rdata[BIT_PRESS] = sts.press;
      reg_rdata[BIT_OVR]   = sts.ovr;
    end else begin
      reg_rdata[BIT_PRESS] = en_q.press;
      reg_rdata[BIT_OVR]   = en_q.ovr;
    end
  end
endmodule

// File: rtl/pwrbtn_ctrl.sv
module pwrbtn_ctrl
  import pwrbtn_pkg::*;
#(
  parameter int DEB_TICKS  = 20,
  parameter int HOLD_TICKS = 4001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          btn_n,
  input  logic          reg_wr,
  input  logic          reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          sys_on,
  output logic          sci
);
  logic      pressed, press_pulse, hold_done, ovr_en, soft_off_cmd;
  evt_bits_t sts;

  pb_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
    .clk(clk), .rst_n(rst_n), .tick(tick), .btn_n(btn_n),
    .pressed(pressed), .press_pulse(press_pulse)
  );

  pb_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pressed(pressed),
    .press_pulse(press_pulse), .sys_on(sys_on), .hold_done(hold_done)
  );

  pb_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .press_pulse(press_pulse), .hold_done(hold_done),
    .sys_on(sys_on), .sci(sci), .ovr_en(ovr_en),
    .soft_off_cmd(soft_off_cmd), .sts(sts)
  );
endmodule

// File: rtl/pwrbtn_ctrl_chk.sv
module pwrbtn_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic press_pulse,
  input logic hold_done,
  input logic sys_on,
  input logic ovr_en,
  input logic soft_off_cmd,
  input logic sts_press,
  input logic sts_ovr
);
  a_r3_press_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    press_pulse |=> sts_press);

  a_r4_off_press_powers_on: assert property (@(posedge clk) disable iff (!rst_n)
    (press_pulse && !sys_on) |=> sys_on);

  a_r6_override_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_done && ovr_en) |=> (!sys_on && sts_ovr));

  a_r7_disabled_no_force: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_done && !ovr_en && !soft_off_cmd && sys_on) |=> sys_on);

  a_r8_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
    hold_done |=> !hold_done);

  a_r5_soft_off: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_off_cmd && !press_pulse) |=> !sys_on);
endmodule

bind pwrbtn_ctrl pwrbtn_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .press_pulse(press_pulse), .hold_done(hold_done),
  .sys_on(sys_on), .ovr_en(ovr_en), .soft_off_cmd(soft_off_cmd),
  .sts_press(sts.press), .sts_ovr(sts.ovr)
);

// File: tb/pwrbtn_ctrl_bench.sv
module pwrbtn_ctrl_bench;
  localparam int DEB  = 3;
  localparam int HOLD = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0, tick = 1'b0, btn_n = 1'b1;
  logic       reg_wr = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       sys_on, sci;
  int         errs = 0, checks = 0;

  always #4 clk = ~clk;

  pwrbtn_ctrl #(.DEB_TICKS(DEB), .HOLD_TICKS(HOLD)) u_pwrbtn_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .btn_n(btn_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sys_on(sys_on), .sci(sci)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk) begin reg_wr = 1'b1; reg_addr = a; reg_wdata = d; end
    @(negedge clk) reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk) reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic press(input int k);
    @(negedge clk) btn_n = 1'b0;
    repeat (4) @(negedge clk);
    ticks(k);
    @(negedge clk) btn_n = 1'b1;
    repeat (4) @(negedge clk);
    ticks(DEB);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic ep, eo, eon;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sys_on", {7'b0, sys_on}, 8'h00);
    chk("R1 sci", {7'b0, sci}, 8'h00);
    rd(1'b0, d); chk("R1 status", d, 8'h00);
    rd(1'b1, d); chk("R1 enable", d, 8'h00);

    // Sweep: start state x override enable x press enable x press length
    for (int st = 0; st < 2; st++)
      for (int oe = 0; oe < 2; oe++)
        for (int pe = 0; pe < 2; pe++)
          for (int k = 0; k <= HOLD + 4; k++) begin
            wr(1'b1, 8'h80);
            if (st == 1) press(DEB);
            wr(1'b0, 8'h03);
            wr(1'b1, {6'b0, oe[0], pe[0]});
            press(k);
            ep  = (k >= DEB);
            eo  = (st == 1) && (oe == 1) && (k >= HOLD);
            eon = (st == 1) ? !eo : ep;
            rd(1'b0, d);
            if (k < DEB) chk("R2 glitch ignored", {7'b0, d[0]}, 8'h00);
            else         chk("R3 press status", {7'b0, d[0]}, {7'b0, ep});
            if (st == 0)      chk("R8 no override from off", {7'b0, d[1]}, 8'h00);
            else if (oe == 1) chk("R6 override status", {7'b0, d[1]}, {7'b0, eo});
            else              chk("R7 override disabled status", {7'b0, d[1]}, 8'h00);
            if (st == 0)      chk(k < DEB ? "R2 sys_on" : "R4 sys_on", {7'b0, sys_on}, {7'b0, eon});
            else if (oe == 1) chk("R6 sys_on", {7'b0, sys_on}, {7'b0, eon});
            else              chk("R7 sys_on", {7'b0, sys_on}, {7'b0, eon});
            chk("R10 sci", {7'b0, sci}, {7'b0, (ep & pe[0]) | (eo & oe[0])});
          end

    // R5 short press while working, then soft-off
    wr(1'b1, 8'h80);
    press(DEB);
    wr(1'b1, 8'h81);
    chk("R5 soft-off clears sys_on", {7'b0, sys_on}, 8'h00);
    rd(1'b1, d); chk("R5 command bit reads 0", d, 8'h01);
    press(DEB);
    press(DEB + 1);
    chk("R5 short press keeps working", {7'b0, sys_on}, 8'h01);

    // R9 write-one-to-clear
    wr(1'b1, 8'h02);
    press(HOLD + 1);
    rd(1'b0, d); chk("R9 both set", d, 8'h03);
    wr(1'b0, 8'h00);
    rd(1'b0, d); chk("R9 write 0 keeps", d, 8'h03);
    wr(1'b0, 8'h02);
    rd(1'b0, d); chk("R9 clear override only", d, 8'h01);
    wr(1'b0, 8'h01);
    rd(1'b0, d); chk("R9 clear press", d, 8'h00);

    // R8 re-arm on each press
    press(DEB);
    chk("R8 back on", {7'b0, sys_on}, 8'h01);
    press(HOLD - 1);
    chk("R8 below threshold stays on", {7'b0, sys_on}, 8'h01);
    press(HOLD);
    chk("R8 second long press fires", {7'b0, sys_on}, 8'h00);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule